// File: doc/BRIEF.md
# Transmit Jabber and Receive Watchdog Guard

This block keeps a network port from holding the medium forever in either direction. On the transmit side a jabber timer measures each frame while the transmitter reports activity. Once a frame runs past a limit, the timer raises a cut-off signal that tells the transmit path to stop driving the line. The limit can be counted in transmitted bytes or in bit times. After a cut-off, the release can come as soon as the transmitter goes idle, or only after a fixed holding interval.

On the receive side a watchdog counts byte times while carrier is present. If carrier outlasts its limit, the watchdog closes the receive gate and emits a one-cycle timeout pulse, which is meant to set a status bit. The gate reopens only after carrier has been absent for a run of bit times, and that quiet run starts over each time carrier returns. A five-bit control word can disable either guard and selects the jabber measure, the release style and the quiet-period length. All limits are parameters, so a simulation can use shortened time constants.

Top module: `link_guard`

## Requirements
- R1: Reset is synchronous and active low. After reset, tx_cutoff is 0, rx_enable is 1 and wd_event is 0.
- R2: With cfg_word[1]=1 (byte measure), cfg_word[0]=0 and tx_active held high, tx_cutoff rises on the clock edge that samples the JAB_BYTES-th byte_tick. A low tx_active restarts the count.
- R3: With cfg_word[1]=0 (time measure), R2 applies with bit_tick counted against JAB_BITS, and byte_tick has no effect.
- R4: cfg_word[0]=1 turns the jabber off. tx_cutoff is 0 from the next edge on and stays 0 while the bit is set, whatever the activity.
- R5: With cfg_word[2]=1 (fast release), an active tx_cutoff clears on the edge that samples tx_active low.
- R6: With cfg_word[2]=0, an active tx_cutoff clears on the first edge at which UNJAB_BITS bit_ticks have been counted since the cut-off and tx_active is sampled low.
- R7: With cfg_word[3]=0, rx_enable falls and wd_event goes high for exactly one cycle on the edge that samples the WD_BYTES-th byte_tick of unbroken carrier. Carrier sampled low restarts the count.
- R8: While the gate is closed, rx_enable stays 0 as long as carrier is present. Carrier sampled high restarts the quiet count.
- R9: A closed gate reopens on the edge after the quiet count reaches QUIET_SHORT bit_ticks of absent carrier (cfg_word[4]=0) or QUIET_LONG bit_ticks (cfg_word[4]=1).
- R10: cfg_word[3]=1 turns the watchdog off. rx_enable is 1 from the next edge on, and no wd_event occurs while the bit is set.
- R11: rx_carrier_out equals rx_carrier when rx_enable is 1 and is 0 otherwise, with no added delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_word | input | 5 | [0] jabber off, [1] byte measure, [2] fast release, [3] watchdog off, [4] long quiet |
| tx_active | input | 1 | Transmitter is sending a frame |
| rx_carrier | input | 1 | Raw receive carrier |
| byte_tick | input | 1 | One-cycle strobe per byte time |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| tx_cutoff | output | 1 | Transmit cut-off |
| rx_enable | output | 1 | Receive gate open |
| rx_carrier_out | output | 1 | Carrier after the receive gate |
| wd_event | output | 1 | One-cycle receive watchdog timeout pulse |

## Verification
The properties assume that every input is synchronous to clk and stays stable across the sampling edge. They also assume that cfg_word may change in any cycle, so each property lets an off bit take over the outputs one edge later. The stimulus changes all inputs on the falling edge only. The strobes are treated as independent single-cycle levels with no spacing rule, and the random part rewrites the control word every few hundred cycles, including the off bits, so the properties are exercised across mode changes.

// File: rtl/link_guard_pkg.sv
// Package: shared control word layout for the link guard.
// Assumes the control word is sampled synchronously to the guard clock.
package link_guard_pkg;

    localparam int CFG_W = 5;

    typedef struct packed {
        logic wd_long_quiet;   // [4] long quiet period before reopening
        logic wd_off;          // [3] receive watchdog disabled
        logic jab_fast_rel;    // [2] release cut-off when transmitter idles
        logic jab_bytes;       // [1] measure frames in bytes, else bit times
        logic jab_off;         // [0] transmit jabber disabled
    } guard_cfg_t;

endpackage

// File: rtl/tx_jabber_timer.sv
// Module: transmit jabber timer.
// Counts byte or bit strobes while the transmitter is active and raises
// a cut-off once the selected limit is reached; releases it either when
// the transmitter idles or after a holding interval of bit strobes.
// Assumes strobes are single-cycle and synchronous to clk.
module tx_jabber_timer #(
    parameter int BYTE_LIMIT    = 2304,
    parameter int TIME_LIMIT    = 2900,
    parameter int RELEASE_TICKS = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic jab_off,
    input  logic bytes_mode,
    input  logic fast_release,
    input  logic tx_active,
    input  logic byte_tick,
    input  logic bit_tick,
    output logic tx_cutoff
);
    localparam int LIM_MAX = (BYTE_LIMIT > TIME_LIMIT) ? BYTE_LIMIT : TIME_LIMIT;
    localparam int CW = $clog2(LIM_MAX + 1);
    localparam int RW = $clog2(RELEASE_TICKS + 1);
    localparam logic [CW-1:0] BYTE_LAST = CW'(BYTE_LIMIT - 1);
    localparam logic [CW-1:0] TIME_LAST = CW'(TIME_LIMIT - 1);
    localparam logic [RW-1:0] REL_LAST  = RW'(RELEASE_TICKS);

    logic [CW-1:0] run_cnt;
    logic [RW-1:0] rel_cnt;
    logic          cut_q;
    logic          run_tick;
    logic [CW-1:0] run_last;
    logic          rel_done;

    // Select the active measure and decide whether release is allowed.
    always_comb begin
        run_tick = bytes_mode ? byte_tick : bit_tick;
        run_last = bytes_mode ? BYTE_LAST : TIME_LAST;
        rel_done = fast_release || (rel_cnt == REL_LAST);
    end

    // Frame length counting, cut-off entry and release sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n || jab_off) begin
            cut_q   <= 1'b0;
            run_cnt <= '0;
            rel_cnt <= '0;
        end else if (!cut_q) begin
            if (!tx_active) begin
                run_cnt <= '0;
            end else if (run_tick) begin
                if (run_cnt >= run_last) begin
                    cut_q   <= 1'b1;
                    run_cnt <= '0;
                    rel_cnt <= '0;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end else begin
            if (!tx_active && rel_done) begin
                cut_q   <= 1'b0;
                rel_cnt <= '0;
            end else if (bit_tick && (rel_cnt != REL_LAST)) begin
                rel_cnt <= rel_cnt + 1'b1;
            end
        end
    end

    assign tx_cutoff = cut_q;

endmodule

// File: rtl/rx_watchdog_gate.sv
// Module: receive watchdog gate.
// Counts byte strobes while carrier is present; on reaching the limit it
// closes the gate and pulses a timeout event, then reopens after a run of
// bit strobes with no carrier. Assumes single-cycle synchronous strobes.
module rx_watchdog_gate #(
    parameter int CARRIER_LIMIT = 2304,
    parameter int QUIET_SHORT   = 20,
    parameter int QUIET_LONG    = 44
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_off,
    input  logic long_quiet,
    input  logic rx_carrier,
    input  logic byte_tick,
    input  logic bit_tick,
    output logic rx_enable,
    output logic wd_event
);
    localparam int CW = $clog2(CARRIER_LIMIT + 1);
    localparam int QMAX = (QUIET_LONG > QUIET_SHORT) ? QUIET_LONG : QUIET_SHORT;
    localparam int QW = $clog2(QMAX + 1);
    localparam logic [CW-1:0] CAR_LAST = CW'(CARRIER_LIMIT - 1);
    localparam logic [QW-1:0] Q_SHORT  = QW'(QUIET_SHORT);
    localparam logic [QW-1:0] Q_LONG   = QW'(QUIET_LONG);

    logic [CW-1:0] car_cnt;
    logic [QW-1:0] quiet_cnt;
    logic          closed_q;
    logic          event_q;
    logic [QW-1:0] quiet_last;

    // Pick the quiet period length from the control word.
    always_comb quiet_last = long_quiet ? Q_LONG : Q_SHORT;

    // Carrier length counting, gate closing and quiet-period reopening.
    always_ff @(posedge clk) begin
        if (!rst_n || wd_off) begin
            closed_q  <= 1'b0;
            event_q   <= 1'b0;
            car_cnt   <= '0;
            quiet_cnt <= '0;
        end else begin
            event_q <= 1'b0;
            if (!closed_q) begin
                if (!rx_carrier) begin
                    car_cnt <= '0;
                end else if (byte_tick) begin
                    if (car_cnt >= CAR_LAST) begin
                        closed_q  <= 1'b1;
                        event_q   <= 1'b1;
                        car_cnt   <= '0;
                        quiet_cnt <= '0;
                    end else begin
                        car_cnt <= car_cnt + 1'b1;
                    end
                end
            end else begin
                if (rx_carrier) begin
                    quiet_cnt <= '0;
                end else if (quiet_cnt >= quiet_last) begin
                    closed_q  <= 1'b0;
                    quiet_cnt <= '0;
                end else if (bit_tick) begin
                    quiet_cnt <= quiet_cnt + 1'b1;
                end
            end
        end
    end

    assign rx_enable = !closed_q;
    assign wd_event  = event_q;

endmodule

// File: rtl/link_guard.sv
// Module: top of the link guard.
// Joins the transmit jabber timer and the receive watchdog gate under one
// control word and gates the receive carrier. Assumes all inputs are
// synchronous to clk; limits are parameters so tests can shorten them.
module link_guard
    import link_guard_pkg::*;
#(
    parameter int JAB_BYTES   = 2304,
    parameter int JAB_BITS    = 2900,
    parameter int UNJAB_BITS  = 3900,
    parameter int WD_BYTES    = 2304,
    parameter int QUIET_SHORT = 20,
    parameter int QUIET_LONG  = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg_word,
    input  logic             tx_active,
    input  logic             rx_carrier,
    input  logic             byte_tick,
    input  logic             bit_tick,
    output logic             tx_cutoff,
    output logic             rx_enable,
    output logic             rx_carrier_out,
    output logic             wd_event
);
    guard_cfg_t cfg;

    // Interpret the raw control word as named fields.
    always_comb cfg = guard_cfg_t'(cfg_word);

    tx_jabber_timer #(
        .BYTE_LIMIT    (JAB_BYTES),
        .TIME_LIMIT    (JAB_BITS),
        .RELEASE_TICKS (UNJAB_BITS)
    ) jabber_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .jab_off      (cfg.jab_off),
        .bytes_mode   (cfg.jab_bytes),
        .fast_release (cfg.jab_fast_rel),
        .tx_active    (tx_active),
        .byte_tick    (byte_tick),
        .bit_tick     (bit_tick),
        .tx_cutoff    (tx_cutoff)
    );

    rx_watchdog_gate #(
        .CARRIER_LIMIT (WD_BYTES),
        .QUIET_SHORT   (QUIET_SHORT),
        .QUIET_LONG    (QUIET_LONG)
    ) wdog_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_off     (cfg.wd_off),
        .long_quiet (cfg.wd_long_quiet),
        .rx_carrier (rx_carrier),
        .byte_tick  (byte_tick),
        .bit_tick   (bit_tick),
        .rx_enable  (rx_enable),
        .wd_event   (wd_event)
    );

    // Pass carrier only while the receive gate is open.
    always_comb rx_carrier_out = rx_carrier && rx_enable;

endmodule

// File: rtl/link_guard_chk.sv
// Module: property checker for the link guard, attached by bind.
// Assumes inputs are synchronous to clk and stable around each edge.
module link_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [4:0] cfg_word,
    input logic       tx_active,
    input logic       rx_carrier,
    input logic       tx_cutoff,
    input logic       rx_enable,
    input logic       wd_event
);
    // R4
    jab_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[0] |=> !tx_cutoff);

    // R2
    cut_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_cutoff) |-> $past(tx_active));

    // R5
    cut_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_cutoff) |-> $past(!tx_active || cfg_word[0]));

    // R7
    event_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_event |=> !wd_event);

    // R7
    event_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wd_event |-> (!rx_enable && $past(rx_enable)));

    // R8
    reopen_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_enable) |-> $past(!rx_carrier || cfg_word[3]));

    // R10
    wd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_word[3] |=> (rx_enable && !wd_event));

endmodule

bind link_guard link_guard_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_word   (cfg_word),
    .tx_active  (tx_active),
    .rx_carrier (rx_carrier),
    .tx_cutoff  (tx_cutoff),
    .rx_enable  (rx_enable),
    .wd_event   (wd_event)
);

// File: tb/link_guard_tb_top.sv
`timescale 1ns/1ps
// Bench: directed corner cases, then seeded random stimulus compared with a
// cycle model derived from the requirements.
module link_guard_tb_top;
    localparam int JB = 24;
    localparam int JT = 40;
    localparam int UB = 30;
    localparam int WB = 20;
    localparam int QS = 8;
    localparam int QL = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] cfg_word = 5'b0;
    logic       tx_active = 1'b0;
    logic       rx_carrier = 1'b0;
    logic       byte_tick = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_cutoff;
    logic       rx_enable;
    logic       rx_carrier_out;
    logic       wd_event;

    int checks = 0;
    int errors = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    link_guard #(
        .JAB_BYTES(JB), .JAB_BITS(JT), .UNJAB_BITS(UB),
        .WD_BYTES(WB), .QUIET_SHORT(QS), .QUIET_LONG(QL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
        .tx_active(tx_active), .rx_carrier(rx_carrier),
        .byte_tick(byte_tick), .bit_tick(bit_tick),
        .tx_cutoff(tx_cutoff), .rx_enable(rx_enable),
        .rx_carrier_out(rx_carrier_out), .wd_event(wd_event)
    );

    // Reference model built from the requirements.
    logic m_cut, m_closed, m_evt;
    int   m_run, m_rel, m_car, m_q;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cut <= 0; m_run <= 0; m_rel <= 0;
            m_closed <= 0; m_evt <= 0; m_car <= 0; m_q <= 0;
        end else begin
            if (cfg_word[0]) begin
                m_cut <= 0; m_run <= 0; m_rel <= 0;
            end else if (!m_cut) begin
                if (!tx_active) m_run <= 0;
                else if (cfg_word[1] ? byte_tick : bit_tick) begin
                    if (m_run + 1 >= (cfg_word[1] ? JB : JT)) begin
                        m_cut <= 1; m_run <= 0; m_rel <= 0;
                    end else m_run <= m_run + 1;
                end
            end else begin
                if (!tx_active && (cfg_word[2] || m_rel >= UB)) begin
                    m_cut <= 0; m_rel <= 0;
                end else if (bit_tick && m_rel < UB) m_rel <= m_rel + 1;
            end
            if (cfg_word[3]) begin
                m_closed <= 0; m_evt <= 0; m_car <= 0; m_q <= 0;
            end else begin
                m_evt <= 0;
                if (!m_closed) begin
                    if (!rx_carrier) m_car <= 0;
                    else if (byte_tick) begin
                        if (m_car + 1 >= WB) begin
                            m_closed <= 1; m_evt <= 1; m_car <= 0; m_q <= 0;
                        end else m_car <= m_car + 1;
                    end
                end else begin
                    if (rx_carrier) m_q <= 0;
                    else if (m_q >= (cfg_word[4] ? QL : QS)) begin
                        m_closed <= 0; m_q <= 0;
                    end else if (bit_tick) m_q <= m_q + 1;
                end
            end
        end
    end

    function automatic logic exp_out(input logic car, input logic closed);
        return car && !closed;
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog on the whole run.
    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int ev_seen;
        void'($urandom(32'd1357));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);
        // R1 reset state
        check("R1 cutoff", tx_cutoff, 1'b0);
        check("R1 rx_enable", rx_enable, 1'b1);
        check("R1 wd_event", wd_event, 1'b0);

        // R2 byte measure with fast release
        cfg_word = 5'b00110; tx_active = 1; byte_tick = 1; bit_tick = 0;
        wait_n(JB - 1); check("R2 before limit", tx_cutoff, 1'b0);
        wait_n(1);      check("R2 at limit", tx_cutoff, 1'b1);
        tx_active = 0;
        wait_n(1);      check("R5 fast release", tx_cutoff, 1'b0);

        // R3 time measure, restart on idle, byte_tick ignored
        cfg_word = 5'b00100; bit_tick = 1; tx_active = 1;
        wait_n(20); tx_active = 0; wait_n(1); tx_active = 1;
        wait_n(JT - 1); check("R3 restart before limit", tx_cutoff, 1'b0);
        wait_n(1);      check("R3 at limit", tx_cutoff, 1'b1);

        // R6 delayed release
        cfg_word = 5'b00000;
        wait_n(5); tx_active = 0;
        wait_n(UB - 5); check("R6 holding", tx_cutoff, 1'b1);
        wait_n(1);      check("R6 released", tx_cutoff, 1'b0);

        // R4 jabber off
        cfg_word = 5'b00110; tx_active = 1;
        wait_n(JB); check("R2 second expiry", tx_cutoff, 1'b1);
        cfg_word = 5'b00111;
        wait_n(1);  check("R4 off clears", tx_cutoff, 1'b0);
        wait_n(60); check("R4 off holds", tx_cutoff, 1'b0);
        tx_active = 0; cfg_word = 5'b00110;

        // R7 watchdog with restart
        rx_carrier = 1; byte_tick = 1;
        wait_n(10); rx_carrier = 0; wait_n(1); rx_carrier = 1;
        wait_n(WB - 1);
        check("R7 restart open", rx_enable, 1'b1);
        check("R7 no event yet", wd_event, 1'b0);
        wait_n(1);
        check("R7 closed", rx_enable, 1'b0);
        check("R7 event", wd_event, 1'b1);
        check("R11 gated carrier", rx_carrier_out, 1'b0);
        wait_n(1);
        check("R7 single pulse", wd_event, 1'b0);

        // R8 stays closed, quiet restarts; R9 short quiet
        wait_n(40); check("R8 closed under carrier", rx_enable, 1'b0);
        rx_carrier = 0; wait_n(6); rx_carrier = 1; wait_n(1); rx_carrier = 0;
        wait_n(QS); check("R8 quiet restarted", rx_enable, 1'b0);
        wait_n(1);  check("R9 short reopen", rx_enable, 1'b1);
        rx_carrier = 1; #1;
        check("R11 open carrier", rx_carrier_out, 1'b1);

        // R9 long quiet
        cfg_word = 5'b10110;
        wait_n(WB); check("R7 closed again", rx_enable, 1'b0);
        rx_carrier = 0;
        wait_n(QL); check("R9 long holding", rx_enable, 1'b0);
        wait_n(1);  check("R9 long reopen", rx_enable, 1'b1);

        // R10 watchdog off
        rx_carrier = 1;
        wait_n(WB); check("R7 closed third", rx_enable, 1'b0);
        cfg_word = 5'b11110;
        wait_n(1); check("R10 off opens", rx_enable, 1'b1);
        ev_seen = 0;
        for (int i = 0; i < 60; i++) begin
            wait_n(1);
            if (wd_event) ev_seen++;
        end
        check("R10 no event", ev_seen != 0, 1'b0);
        check("R10 stays open", rx_enable, 1'b1);

        // Reset both sides, then random stimulus against the model
        rst_n = 0; tx_active = 0; rx_carrier = 0; cfg_word = 5'b00110;
        wait_n(2); rst_n = 1;
        wait_n(1);
        check("R1 reset again", rx_enable, 1'b1);
        for (int c = 0; c < 6000; c++) begin
            check("R2 cutoff model", tx_cutoff, m_cut);
            check("R7 enable model", rx_enable, !m_closed);
            check("R7 event model", wd_event, m_evt);
            check("R11 carrier model", rx_carrier_out, exp_out(rx_carrier, m_closed));
            if (c % 400 == 0) begin
                cfg_word = 5'($urandom);
                if ($urandom % 4 != 0) cfg_word[0] = 0;
                if ($urandom % 4 != 0) cfg_word[3] = 0;
            end
            if ($urandom % 60 == 0) tx_active = !tx_active;
            if ($urandom % 50 == 0) rx_carrier = !rx_carrier;
            byte_tick = ($urandom % 2) == 0;
            bit_tick  = ($urandom % 4) != 0;
            wait_n(1);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule